// File: doc/BRIEF.md
# Denormals-are-zero operand conditioning unit

This block sits in front of a packed single-precision arithmetic unit. It holds the SIMD floating-point control/status word and conditions two 128-bit source operands, each made of four 32-bit lanes, before they are consumed. It finds every denormal lane in both operands. When the flush mode bit is set, each denormal lane is replaced by a zero of the same sign, and no denormal status or exception is produced. When the mode bit is clear, the lanes pass through unchanged, a sticky status flag records the denormal, and an exception request is raised if the denormal exception is unmasked.

The control/status word is written through a single write port. A parameter gives the set of writable bits. The flush mode bit is writable only when the feature-present parameter is set. A write that sets any bit outside the writable set is refused, and a fault pulse is produced.

Top module: `dnz_operand_cond`

## Requirements
- R1: A lane is denormal when its exponent field, bits 30:23, is all zeros and its fraction field, bits 22:0, is not zero. A lane that is zero, of either sign, is never treated as denormal.
- R2: When control bit 6 is set, every denormal lane of both operands comes out as a zero that keeps the lane's bit 31. All other lanes come out unchanged. Results are registered and appear one clock after the input is accepted.
- R3: When control bit 6 is clear, every lane passes through unchanged. If any lane of a valid input is denormal, the sticky flag in control bit 1 is set on the next clock.
- R4: When control bit 6 is set, a denormal lane never sets bit 1 and never raises `dn_exc`, for either value of mask bit 8.
- R5: When control bit 6 is clear, `dn_exc` pulses one clock after a valid input that holds a denormal lane, and only if mask bit 8 is 0.
- R6: Synchronous reset loads the control word with `RST_VAL` with bit 6 forced to 0. Reset also clears `res_valid`, `dn_exc` and `csr_wr_fault`.
- R7: The writable set is `BASE_WMASK` without bit 6, plus bit 6 when `FEAT_DAZ` is 1 (default base: bits 15:0 except bit 6). A write that sets any bit outside this set pulses `csr_wr_fault` on the next clock and leaves the control word unchanged.
- R8: When `FEAT_DAZ` is 0, a write that sets bit 6 faults, so bit 6 can never become 1.
- R9: The sticky flag is cleared only by a register write or by reset. A valid input with no denormal lane leaves it set. When a write and an input arrive on the same clock, the written value is loaded, the flag set by the input is ORed into it, and the input is conditioned under the mode in force before the write.
- R10: `res_valid` is `op_valid` delayed by one clock. `res_a` and `res_b` hold their last values while no input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_wr_en | input | 1 | Control word write strobe |
| csr_wr_data | input | 32 | Value to write |
| csr_wr_fault | output | 1 | Pulse: the previous write was refused |
| csr_q | output | 32 | Current control/status word |
| op_valid | input | 1 | Source operands valid this clock |
| op_a | input | 128 | First source operand, four lanes |
| op_b | input | 128 | Second source operand, four lanes |
| res_valid | output | 1 | Conditioned operands valid |
| res_a | output | 128 | Conditioned first operand |
| res_b | output | 128 | Conditioned second operand |
| dn_exc | output | 1 | Denormal-operand exception request |

## Verification
The embedded assertions check several properties on every clock:
- no exception request and no new sticky flag while flushing is on;
- no denormal lane leaves the block while flushing is on;
- a refused write changes no bit other than the flag;
- the flag is never lost without a write;
- the mode bit never rises on a build without the feature;
- `res_valid` follows `op_valid` by one clock.

Only the bench's scenarios can show the rest, because a behavioural model is compared against both a feature-present and a feature-absent instance on every clock. These are:
- the exact lane values, including sign retention and the treatment of signed zeros and all-ones-exponent lanes;
- the unmasked exception in pass-through mode;
- the same-clock ordering of a write and an input.

// File: rtl/dnz_operand_cond.sv
module dnz_operand_cond #(
  parameter int LANES = 4,
  parameter int LANE_W = 32,
  parameter int EXP_W = 8,
  parameter int CSR_W = 32,
  parameter bit FEAT_DAZ = 1'b1,
  parameter int FLAG_BIT = 1,
  parameter int MODE_BIT = 6,
  parameter int MASK_BIT = 8,
  parameter logic [CSR_W-1:0] BASE_WMASK = 32'h0000_FFBF,
  parameter logic [CSR_W-1:0] RST_VAL = 32'h0000_1F80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     csr_wr_en,
  input  logic [CSR_W-1:0]         csr_wr_data,
  output logic                     csr_wr_fault,
  output logic [CSR_W-1:0]         csr_q,
  input  logic                     op_valid,
  input  logic [LANES*LANE_W-1:0]  op_a,
  input  logic [LANES*LANE_W-1:0]  op_b,
  output logic                     res_valid,
  output logic [LANES*LANE_W-1:0]  res_a,
  output logic [LANES*LANE_W-1:0]  res_b,
  output logic                     dn_exc
);
  localparam int FRAC_W = LANE_W - 1 - EXP_W;
  localparam int VEC_W = LANES * LANE_W;
  localparam logic [CSR_W-1:0] MODE_ONE = CSR_W'(1) << MODE_BIT;
  localparam logic [CSR_W-1:0] FLAG_ONE = CSR_W'(1) << FLAG_BIT;
  localparam logic [CSR_W-1:0] WMASK = (BASE_WMASK & ~MODE_ONE) | (FEAT_DAZ ? MODE_ONE : '0);
  localparam logic [CSR_W-1:0] RST_Q = RST_VAL & ~MODE_ONE;

  logic [CSR_W-1:0] csr_r, csr_nxt;
  logic [LANES-1:0] dn_a, dn_b;
  logic [VEC_W-1:0] fl_a, fl_b;
  logic daz, masked, flag_set, wr_bad, wr_ok;

  assign daz = csr_r[MODE_BIT];
  assign masked = csr_r[MASK_BIT];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a, b;
    assign a = op_a[i*LANE_W +: LANE_W];
    assign b = op_b[i*LANE_W +: LANE_W];
    assign dn_a[i] = (a[FRAC_W +: EXP_W] == '0) && (a[FRAC_W-1:0] != '0);
    assign dn_b[i] = (b[FRAC_W +: EXP_W] == '0) && (b[FRAC_W-1:0] != '0);
    assign fl_a[i*LANE_W +: LANE_W] = (daz && dn_a[i]) ? {a[LANE_W-1], {(LANE_W-1){1'b0}}} : a;
    assign fl_b[i*LANE_W +: LANE_W] = (daz && dn_b[i]) ? {b[LANE_W-1], {(LANE_W-1){1'b0}}} : b;
  end

  assign flag_set = op_valid && (|{dn_a, dn_b}) && !daz;
  assign wr_bad = |(csr_wr_data & ~WMASK);
  assign wr_ok = csr_wr_en && !wr_bad;
  assign csr_nxt = (wr_ok ? csr_wr_data : csr_r) | (flag_set ? FLAG_ONE : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_r        <= RST_Q;
      csr_wr_fault <= 1'b0;
      res_valid    <= 1'b0;
      dn_exc       <= 1'b0;
    end else begin
      csr_r        <= csr_nxt;
      csr_wr_fault <= csr_wr_en && wr_bad;
      res_valid    <= op_valid;
      dn_exc       <= flag_set && !masked;
    end
  end

  always_ff @(posedge clk) begin
    if (op_valid) begin
      res_a <= fl_a;
      res_b <= fl_b;
    end
  end

  assign csr_q = csr_r;

  function automatic logic has_dn(input logic [VEC_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (v[k*LANE_W + FRAC_W +: EXP_W] == '0 && v[k*LANE_W +: FRAC_W] != '0) r = 1'b1;
    return r;
  endfunction

  // R4
  no_exc_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
    dn_exc |-> !$past(csr_q[MODE_BIT]));

  // R4
  no_flag_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(csr_q[MODE_BIT]) && !$past(csr_wr_en) && !$past(csr_q[FLAG_BIT])) |-> !csr_q[FLAG_BIT]);

  // R2
  no_denorm_out_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(rst) && $past(csr_q[MODE_BIT])) |-> !(has_dn(res_a) || has_dn(res_b)));

  // R7
  fault_keeps_csr_chk: assert property (@(posedge clk) disable iff (rst)
    csr_wr_fault |-> ((csr_q ^ $past(csr_q)) & ~FLAG_ONE) == '0);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(csr_q[FLAG_BIT]) && !$past(csr_wr_en)) |-> csr_q[FLAG_BIT]);

  // R8
  no_mode_without_feat_chk: assert property (@(posedge clk) disable iff (rst)
    FEAT_DAZ || !csr_q[MODE_BIT]);

  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(op_valid)));
endmodule

// File: tb/tb_dnz_operand_cond.sv
`timescale 1ns/1ps
module tb_dnz_operand_cond;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic we = 1'b0, v = 1'b0;
  logic [31:0] wd = '0;
  logic [127:0] a = '0, b = '0;

  logic [1:0] f_fault, f_rv, f_exc;
  logic [31:0] f_csr [2];
  logic [127:0] f_ra [2];
  logic [127:0] f_rb [2];

  dnz_operand_cond #(.FEAT_DAZ(1'b1)) dut (
    .clk(clk), .rst(rst), .csr_wr_en(we), .csr_wr_data(wd), .csr_wr_fault(f_fault[0]),
    .csr_q(f_csr[0]), .op_valid(v), .op_a(a), .op_b(b), .res_valid(f_rv[0]),
    .res_a(f_ra[0]), .res_b(f_rb[0]), .dn_exc(f_exc[0]));

  dnz_operand_cond #(.FEAT_DAZ(1'b0)) dut_nf (
    .clk(clk), .rst(rst), .csr_wr_en(we), .csr_wr_data(wd), .csr_wr_fault(f_fault[1]),
    .csr_q(f_csr[1]), .op_valid(v), .op_a(a), .op_b(b), .res_valid(f_rv[1]),
    .res_a(f_ra[1]), .res_b(f_rb[1]), .dn_exc(f_exc[1]));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0, armed = 1'b0;

  logic [31:0] m_csr [2];
  logic [127:0] m_ra [2];
  logic [127:0] m_rb [2];
  bit m_fault [2];
  bit m_rv [2];
  bit m_exc [2];

  function automatic bit lane_dn(input logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 23'h0);
  endfunction

  function automatic logic [127:0] flush(input logic [127:0] x, input bit on);
    logic [127:0] r;
    r = x;
    for (int k = 0; k < 4; k++)
      if (on && lane_dn(x[k*32 +: 32])) r[k*32 +: 32] = {x[k*32+31], 31'h0};
    return r;
  endfunction

  function automatic bit any_dn(input logic [127:0] x, input logic [127:0] y);
    bit r;
    r = 0;
    for (int k = 0; k < 4; k++) r = r | lane_dn(x[k*32 +: 32]) | lane_dn(y[k*32 +: 32]);
    return r;
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    for (int k = 0; k < 2; k++) begin
      logic [31:0] wm, nxt;
      bit dz, fs, bad;
      if (rst) begin
        m_csr[k] = 32'h0000_1F80;
        m_fault[k] = 0; m_rv[k] = 0; m_exc[k] = 0;
      end else begin
        wm = 32'h0000_FFBF | ((k == 0) ? 32'h40 : 32'h0);
        dz = m_csr[k][6];
        fs = v && any_dn(a, b) && !dz;
        bad = we && ((wd & ~wm) != 0);
        nxt = (we && !bad) ? wd : m_csr[k];
        if (fs) nxt[1] = 1'b1;
        m_exc[k] = fs && !m_csr[k][8];
        m_fault[k] = bad;
        m_rv[k] = v;
        if (v) begin
          m_ra[k] = flush(a, dz);
          m_rb[k] = flush(b, dz);
        end
        m_csr[k] = nxt;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      for (int k = 0; k < 2; k++) begin
        check(f_csr[k] === m_csr[k], "R3 R7 R8 R9", "csr_q", 128'(f_csr[k]), 128'(m_csr[k]));
        check(f_fault[k] === m_fault[k], "R7 R8", "csr_wr_fault", 128'(f_fault[k]), 128'(m_fault[k]));
        check(f_rv[k] === m_rv[k], "R10", "res_valid", 128'(f_rv[k]), 128'(m_rv[k]));
        check(f_exc[k] === m_exc[k], "R4 R5", "dn_exc", 128'(f_exc[k]), 128'(m_exc[k]));
        if (m_rv[k]) begin
          check(f_ra[k] === m_ra[k], "R1 R2 R3", "res_a", f_ra[k], m_ra[k]);
          check(f_rb[k] === m_rb[k], "R1 R2 R3", "res_b", f_rb[k], m_rb[k]);
        end
      end
    end
  end

  task automatic drive(input bit w, input logic [31:0] d, input bit vv,
                       input logic [127:0] x, input logic [127:0] y);
    @(negedge clk);
    we = w; wd = d; v = vv; a = x; b = y;
  endtask

  function automatic logic [31:0] rnd_lane();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: r[30:23] = 8'h00;
      1: r = {r[31], 31'h0};
      2: r = {r[31], 8'h00, 23'h1};
      3: r = {r[31], 8'h00, 23'h7FFFFF};
      4: r[30:23] = 8'hFF;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] rnd_vec();
    return {rnd_lane(), rnd_lane(), rnd_lane(), rnd_lane()};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  localparam logic [127:0] MIX = {32'h8000_0001, 32'h0000_0000, 32'h3F80_0000, 32'h007F_FFFF};
  localparam logic [127:0] NODN = {32'h8000_0000, 32'h7F80_0000, 32'h4000_0000, 32'h0000_0000};

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    for (int k = 0; k < 2; k++) begin
      check(f_csr[k] === 32'h0000_1F80, "R6", "reset csr_q", 128'(f_csr[k]), 128'h1F80);
      check(f_rv[k] === 1'b0, "R6", "reset res_valid", 128'(f_rv[k]), 128'h0);
      check(f_exc[k] === 1'b0, "R6", "reset dn_exc", 128'(f_exc[k]), 128'h0);
      check(f_fault[k] === 1'b0, "R6", "reset fault", 128'(f_fault[k]), 128'h0);
    end
    rst = 1'b0;
    // R3: pass-through, masked: flag set, no exception
    drive(0, 0, 1, MIX, NODN);
    drive(0, 0, 1, NODN, NODN);   // R9: flag stays set
    // R5: unmask, clear flag
    drive(1, 32'h0000_1E80, 0, 0, 0);
    drive(0, 0, 1, NODN, MIX);
    drive(0, 0, 0, 0, 0);
    // R2 R4: enable flush, clear flag, mask open
    drive(1, 32'h0000_1EC0, 0, 0, 0);
    drive(0, 0, 1, MIX, MIX);
    drive(0, 0, 1, {4{32'h8000_0005}}, {4{32'h0000_0000}});
    // R4: flush with mask set
    drive(1, 32'h0000_1FC0, 1, MIX, MIX);
    drive(0, 0, 1, MIX, NODN);
    // R7: illegal bit outside writable set
    drive(1, 32'h0010_0000, 0, 0, 0);
    drive(1, 32'hFFFF_FFFF, 1, MIX, MIX);
    // R9: same-clock write and input under old mode
    drive(1, 32'h0000_1E80, 1, MIX, NODN);
    drive(1, 32'h0000_1E80, 1, MIX, MIX);
    drive(0, 0, 0, 0, 0);
    // R8: feature-absent build refuses bit 6
    drive(1, 32'h0000_0040, 0, 0, 0);
    drive(0, 0, 1, MIX, MIX);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom & 32'h0000_FFFF;
      if ($urandom % 10 == 0) d = d | (32'h1 << ($urandom % 32));
      drive(($urandom % 8) == 0, d, ($urandom % 4) != 0, rnd_vec(), rnd_vec());
    end
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule